// File: doc/BRIEF.md
# Reference Clock Output Gate and Power-Down Controller

This block sits behind a clock buffer's reference input and gates eight copies of that clock onto eight outputs. An output runs only when three conditions hold at once: the global power-good input is high, the output's own active-low enable pin is low, and its control-register enable bit is set. An output that is not enabled is held low on both of its phases. Every change of an enable condition reaches the output after a fixed latency counted in reference-clock cycles. The gate only switches while the clock is low, so no shortened pulse can appear.

The block also captures two strap inputs, the frequency select and the three-level PLL mode, on the first power-good rising edge after reset. It then resolves the effective PLL mode from either the captured strap or a software override. The readback of the straps always shows the captured values. The register bits come in as plain inputs from a control-register block that lives elsewhere.

Top module: `refclk_gate_ctrl`

## Requirements
- R1: While reset is held, all clock outputs are low, `pll_on_o` is 0, the mode readback is 00 and the frequency readback is 1.
- R2: On the first power-good rising edge after reset, the straps are captured, and the readbacks hold them no later than the 4th rising reference edge after the pin change. Frequency readback 1 means 100 MHz and 0 means 133.33 MHz.
- R3: The mode strap codes decode as 00 = PLL low bandwidth, 11 = PLL high bandwidth, and 01 or 10 = bypass. Bypass is stored and reported as 01.
- R4: Later power-good rising edges do not capture the straps again. The readbacks keep their first values.
- R5: With power-good low, `pll_on_o` falls by the 2nd rising edge, and every output stops whatever the enable pins and bits are.
- R6: With power-good high, output i runs only when `out_en_i[i]` is 1 and `oe_n_i[i]` is 0. It is parked low otherwise.
- R7: When an enable input changes during the low phase, the high phase after the 5th following rising edge still shows the old state and the high phase after the 6th shows the new state.
- R8: A clock output is never high while the reference clock is low. The gate state changes only at falling reference edges.
- R9: With `sw_mode_en_i` at 1, `pll_mode_o` follows `sw_mode_i` (10 read as 01). With it at 0, `pll_mode_o` shows the captured strap. The readback is unaffected in both cases.
- R10: `pll_on_o` is 1 only when power-good is high (synchronised), the straps have been captured and the effective mode is not bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock, gated to the outputs and clocking all state |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrgd_i | input | 1 | Power-good; low requests power-down |
| oe_n_i | input | 8 | Per-output active-low enable pins |
| out_en_i | input | 8 | Per-output register enable bits |
| freq_strap_i | input | 1 | Frequency select strap (1 = 100 MHz) |
| mode_strap_i | input | 2 | Pre-decoded three-level PLL mode strap |
| sw_mode_en_i | input | 1 | Software override enable for PLL mode |
| sw_mode_i | input | 2 | Software PLL mode code |
| clk_o | output | 8 | Gated clock outputs |
| pll_mode_o | output | 2 | Effective PLL mode code |
| pll_on_o | output | 1 | PLL active flag |
| mode_rb_o | output | 2 | Captured mode strap readback |
| freq_rb_o | output | 1 | Captured frequency strap readback |

## Verification
The assertions check on every cycle that the strap readbacks never move once captured and keep their reset values before capture. They also check that the PLL flag is never set in bypass or before capture, that it drops soon after power-good falls, and that all gate enables clear after a long enough power-down. The latency values at exactly the 5th and 6th edges, the three-way enable combinations per output, the low-phase parking of running outputs, the override sequence and the refusal to capture again after a power-down cycle can only be shown by the bench scenarios, which drive the pins and sample the outputs in chosen phases.

// File: rtl/refclk_gate_pkg.sv
package refclk_gate_pkg;
  localparam logic [1:0] MODE_LOBW = 2'b00;
  localparam logic [1:0] MODE_BYP  = 2'b01;
  localparam logic [1:0] MODE_HIBW = 2'b11;

  function automatic logic [1:0] decode_mode(input logic [1:0] code);
    return (code == 2'b10) ? MODE_BYP : code;
  endfunction
endpackage

// File: rtl/rgc_sync.sv
module rgc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rgc_strap_latch.sv
module rgc_strap_latch
  import refclk_gate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwrgd_s_i,
  input  logic       freq_i,
  input  logic [1:0] mode_i,
  output logic       freq_o,
  output logic [1:0] mode_o,
  output logic       latched_o
);
  logic pwrgd_d_q;
  logic capture;

  assign capture = pwrgd_s_i && !pwrgd_d_q && !latched_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwrgd_d_q <= 1'b0;
      latched_o <= 1'b0;
      freq_o    <= 1'b1;
      mode_o    <= MODE_LOBW;
    end else begin
      pwrgd_d_q <= pwrgd_s_i;
      if (capture) begin
        latched_o <= 1'b1;
        freq_o    <= freq_i;
        mode_o    <= decode_mode(mode_i);
      end
    end
  end
endmodule

// File: rtl/rgc_out_gate.sv
module rgc_out_gate #(
  parameter int DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic en_q_o,
  output logic clk_o
);
  logic [DLY-1:0] pipe_q;
  logic           en_neg_q;

  for (genvar k = 0; k < DLY; k++) begin : g_dly
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[k] <= 1'b0;
        else         pipe_q[k] <= cond_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[k] <= 1'b0;
        else         pipe_q[k] <= pipe_q[k-1];
      end
    end
  end

  assign en_q_o = pipe_q[DLY-1];

  // retime to the falling edge so the AND below only switches in the low phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_neg_q <= 1'b0;
    else         en_neg_q <= en_q_o;
  end

  assign clk_o = clk_i & en_neg_q;
endmodule

// File: rtl/refclk_gate_ctrl.sv
module refclk_gate_ctrl
  import refclk_gate_pkg::*;
#(
  parameter int NUM_OUT     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LATENCY     = 5
) (
  input  logic               ref_clk_i,
  input  logic               rst_ni,
  input  logic               pwrgd_i,
  input  logic [NUM_OUT-1:0] oe_n_i,
  input  logic [NUM_OUT-1:0] out_en_i,
  input  logic               freq_strap_i,
  input  logic [1:0]         mode_strap_i,
  input  logic               sw_mode_en_i,
  input  logic [1:0]         sw_mode_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [1:0]         pll_mode_o,
  output logic               pll_on_o,
  output logic [1:0]         mode_rb_o,
  output logic               freq_rb_o
);
  localparam int DLY    = LATENCY - SYNC_STAGES;
  localparam int SYNC_W = 2 * NUM_OUT + 1;

  logic [SYNC_W-1:0]  sync_q;
  logic               pwrgd_s;
  logic [NUM_OUT-1:0] oe_n_s;
  logic [NUM_OUT-1:0] out_en_s;
  logic [NUM_OUT-1:0] cond_s;
  logic [NUM_OUT-1:0] gate_en;
  logic               strap_latched;

  rgc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pwrgd_i, oe_n_i, out_en_i}),
    .q_o    (sync_q)
  );

  assign {pwrgd_s, oe_n_s, out_en_s} = sync_q;
  assign cond_s = {NUM_OUT{pwrgd_s}} & out_en_s & ~oe_n_s;

  rgc_strap_latch i_strap (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .pwrgd_s_i (pwrgd_s),
    .freq_i    (freq_strap_i),
    .mode_i    (mode_strap_i),
    .freq_o    (freq_rb_o),
    .mode_o    (mode_rb_o),
    .latched_o (strap_latched)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    rgc_out_gate #(.DLY(DLY)) i_gate (
      .clk_i  (ref_clk_i),
      .rst_ni (rst_ni),
      .cond_i (cond_s[i]),
      .en_q_o (gate_en[i]),
      .clk_o  (clk_o[i])
    );
  end

  assign pll_mode_o = sw_mode_en_i ? decode_mode(sw_mode_i) : mode_rb_o;
  assign pll_on_o   = pwrgd_s && strap_latched && (pll_mode_o != MODE_BYP);
endmodule

module rgc_chk
  import refclk_gate_pkg::*;
#(
  parameter int NUM_OUT = 8,
  parameter int LATENCY = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pwrgd_i,
  input logic               pll_on_o,
  input logic [1:0]         pll_mode_o,
  input logic [1:0]         mode_rb_o,
  input logic               freq_rb_o,
  input logic               latched_i,
  input logic [NUM_OUT-1:0] gate_en_i
);
  localparam int CW = $clog2(LATENCY + 1) + 1;
  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       low_cnt_q <= '0;
    else if (pwrgd_i)                  low_cnt_q <= '0;
    else if (low_cnt_q < CW'(LATENCY)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  // R4
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_i && $past(latched_i)) |-> ($stable(mode_rb_o) && $stable(freq_rb_o)));

  // R1
  strap_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latched_i |-> (!pll_on_o && mode_rb_o == MODE_LOBW && freq_rb_o));

  // R10
  pll_off_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_on_o |-> (pll_mode_o != MODE_BYP));

  // R5
  pd_pll_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_cnt_q >= CW'(2)) |-> !pll_on_o);

  // R5
  pd_gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_cnt_q >= CW'(LATENCY)) |-> (gate_en_i == '0));
endmodule

bind refclk_gate_ctrl rgc_chk #(.NUM_OUT(NUM_OUT), .LATENCY(LATENCY)) i_rgc_chk (
  .clk_i      (ref_clk_i),
  .rst_ni     (rst_ni),
  .pwrgd_i    (pwrgd_i),
  .pll_on_o   (pll_on_o),
  .pll_mode_o (pll_mode_o),
  .mode_rb_o  (mode_rb_o),
  .freq_rb_o  (freq_rb_o),
  .latched_i  (strap_latched),
  .gate_en_i  (gate_en)
);

// File: tb/test_refclk_gate_ctrl.sv
module test_refclk_gate_ctrl;
  localparam int CLK_P = 10;
  localparam int N     = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pwrgd = 1'b0;
  logic [N-1:0] oe_n = '0;
  logic [N-1:0] out_en = '1;
  logic         freq_strap = 1'b0;
  logic [1:0]   mode_strap = 2'b11;
  logic         sw_en = 1'b0;
  logic [1:0]   sw_mode = 2'b00;
  logic [N-1:0] clk_o;
  logic [1:0]   pll_mode;
  logic         pll_on;
  logic [1:0]   mode_rb;
  logic         freq_rb;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  refclk_gate_ctrl i_refclk_gate_ctrl (
    .ref_clk_i    (clk),
    .rst_ni       (rst_n),
    .pwrgd_i      (pwrgd),
    .oe_n_i       (oe_n),
    .out_en_i     (out_en),
    .freq_strap_i (freq_strap),
    .mode_strap_i (mode_strap),
    .sw_mode_en_i (sw_en),
    .sw_mode_i    (sw_mode),
    .clk_o        (clk_o),
    .pll_mode_o   (pll_mode),
    .pll_on_o     (pll_on),
    .mode_rb_o    (mode_rb),
    .freq_rb_o    (freq_rb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // move into the low phase of the current cycle
  task automatic to_low();
    @(posedge clk);
    #(CLK_P*7/10);
  endtask

  // n rising edges, then sample in the high phase
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic lat_check(input string req, input logic [N-1:0] old_m, input logic [N-1:0] new_m);
    edges(5);
    check({req, " edge5"}, clk_o, old_m);
    edges(1);
    check({req, " edge6"}, clk_o, new_m);
  endtask

  task automatic t_reset();
    #(CLK_P*3);
    check("R1 clk_o", clk_o, 0);
    check("R1 pll_on", pll_on, 0);
    check("R1 mode_rb", mode_rb, 2'b00);
    check("R1 freq_rb", freq_rb, 1);
    to_low();
    rst_n = 1'b1;
    edges(3);
    check("R1 clk_o after release", clk_o, 0);
  endtask

  task automatic t_power_up();
    to_low();
    pwrgd = 1'b1;
    edges(4);
    check("R2 mode_rb", mode_rb, 2'b11);
    check("R2 freq_rb 133", freq_rb, 0);
    check("R10 pll_on", pll_on, 1);
    check("R3 pll_mode hibw", pll_mode, 2'b11);
    edges(1);
    check("R7 power-up edge5", clk_o, 0);
    edges(1);
    check("R7 power-up edge6", clk_o, 8'hFF);
  endtask

  task automatic t_pin_disable();
    to_low();
    oe_n[3] = 1'b1;
    lat_check("R7 R6 pin off", 8'hFF, 8'hF7);
    to_low();
    oe_n[3] = 1'b0;
    lat_check("R7 pin on", 8'hF7, 8'hFF);
  endtask

  task automatic t_bit_disable();
    to_low();
    out_en[5] = 1'b0;
    lat_check("R6 bit off", 8'hFF, 8'hDF);
    to_low();
    oe_n[5] = 1'b1;
    out_en[1] = 1'b0;
    oe_n[1] = 1'b1;
    edges(8);
    check("R6 both off", clk_o, 8'hDD);
    to_low();
    oe_n = '0;
    out_en = '1;
    edges(8);
    check("R6 all back", clk_o, 8'hFF);
  endtask

  task automatic t_low_phase();
    for (int k = 0; k < 4; k++) begin
      to_low();
      check("R8 low phase parked", clk_o, 0);
    end
  endtask

  task automatic t_override();
    to_low();
    sw_en = 1'b1;
    sw_mode = 2'b01;
    #1;
    check("R9 sw bypass mode", pll_mode, 2'b01);
    check("R10 sw bypass off", pll_on, 0);
    check("R9 rb kept", mode_rb, 2'b11);
    sw_mode = 2'b10;
    #1;
    check("R9 sw 10 as bypass", pll_mode, 2'b01);
    sw_mode = 2'b00;
    #1;
    check("R9 sw lobw", pll_mode, 2'b00);
    check("R10 sw lobw on", pll_on, 1);
    sw_en = 1'b0;
    #1;
    check("R9 back to strap", pll_mode, 2'b11);
  endtask

  task automatic t_power_down();
    to_low();
    pwrgd = 1'b0;
    edges(2);
    check("R5 pll off", pll_on, 0);
    edges(3);
    check("R5 edge5", clk_o, 8'hFF);
    edges(1);
    check("R5 edge6 stopped", clk_o, 0);
    to_low();
    oe_n = '0;
    out_en = '1;
    edges(4);
    check("R5 pins ignored", clk_o, 0);
    to_low();
    mode_strap = 2'b01;
    freq_strap = 1'b1;
    pwrgd = 1'b1;
    edges(6);
    check("R4 mode_rb kept", mode_rb, 2'b11);
    check("R4 freq_rb kept", freq_rb, 0);
    check("R4 resume clocks", clk_o, 8'hFF);
  endtask

  task automatic t_bypass_strap();
    to_low();
    rst_n = 1'b0;
    pwrgd = 1'b0;
    #1;
    check("R1 reset clears outputs", clk_o, 0);
    mode_strap = 2'b10;
    freq_strap = 1'b1;
    to_low();
    rst_n = 1'b1;
    to_low();
    pwrgd = 1'b1;
    edges(6);
    check("R3 strap 10 bypass", mode_rb, 2'b01);
    check("R2 freq 100", freq_rb, 1);
    check("R3 bypass pll off", pll_on, 0);
    check("R3 bypass clocks run", clk_o, 8'hFF);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_pin_disable();
    t_bit_disable();
    t_low_phase();
    t_override();
    t_power_down();
    t_bypass_strap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_P*20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule